// File: doc/BRIEF.md
# I2C Target with Auto-Incrementing Word Pointer

This block is an I2C target that runs entirely on the system clock. It oversamples SCL and SDA. It recognises START, repeated START and STOP, and it responds to one fixed 7-bit address. Through that address it gives byte access to a 64-entry space. Entries 0 to 7 hold time-keeping and control bytes: seconds, minutes, century/hours, weekday, day of month, month, year and control, in that order. Entries 8 to 63 are general-purpose RAM. The storage lives outside the block and is reached through a simple register port. The port presents the current word pointer as the address, gives a one-cycle write strobe, and takes combinational read data.

A write transfer loads the word pointer from the first byte after the address. It then stores each following byte at the pointer and advances the pointer. A read transfer returns bytes starting at the pointer. The pointer advances only when the controller acknowledges a byte. A read that is not preceded by a pointer write resumes where the previous access left the pointer. A power-fail input stops any transfer, zeroes the pointer and makes the block deaf to the bus for as long as it is held. SDA is open-drain: the block only ever pulls the line low, through a dedicated output.

Top module: `i2c_word_target`

## Requirements
- R1: The block acknowledges an address byte whose upper 7 bits equal 1101000, so 0xD0 selects a write and 0xD1 selects a read. Any other address gets no acknowledge, and the rest of that transfer causes no write and no pointer change.
- R2: START (SDA falls while SCL is high) and STOP (SDA rises while SCL is high) are detected at any point, including a repeated START. Bytes are shifted MSB first. The block asserts its SDA pull-down only while SCL is low.
- R3: In a write transfer the block loads the byte after the address into the pointer, using its low 6 bits. It acknowledges the address, the pointer byte and every data byte. It writes each data byte at the pointer and then increments the pointer.
- R4: A random read is a pointer write, a repeated START, then 0xD1. It returns the byte at the pointer, followed by consecutive bytes for as long as the controller acknowledges.
- R5: During a read the pointer increments only on a controller acknowledge. After a NACK the block releases SDA and the pointer stays at the NACKed byte's address.
- R6: A read that is not preceded by a pointer write starts at the pointer left by the previous access.
- R7: The pointer wraps from 63 to 0 on both reads and writes.
- R8: While pwr_fail_i is high, the transfer in progress ends, the pointer becomes 0 on the next cycle, and the SDA pull-down is released. All bus activity is ignored: no acknowledge and no write.
- R9: reg_addr_o always shows the pointer. reg_we_o pulses for exactly one cycle per received data byte, with reg_addr_o steady across the pulse. After reset the pointer is 0, reg_we_o is 0 and SDA is released.
- R10: The byte to be sent is captured from reg_rdata_i at the acknowledge that precedes it. Later changes on reg_rdata_i do not alter a byte already being shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pwr_fail_i | input | 1 | Supply-fail indication; aborts and blocks access |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_drive_low_o | output | 1 | High pulls SDA low (open-drain drive) |
| reg_addr_o | output | 6 | Word pointer, used as storage address |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_wdata_o | output | 8 | Byte to write |
| reg_rdata_i | input | 8 | Storage byte at reg_addr_o |

## Verification
A corrupted pointer shows up at once on reg_addr_o. It then shows on the bus as a wrong byte in the next read, or as a write landing at the wrong entry. A state machine stuck in the wrong phase shows within one byte time: an acknowledge is missing, or the pull-down is asserted where the controller expects a released line. A slip in the bit counter shifts read data by one position on the very next byte returned. The bench compares every returned byte and every stored byte against a model kept from the requirements. It also checks the pointer on the port after each transfer.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_ADDR,
    ST_PTR,
    ST_ACK_PTR,
    ST_WR,
    ST_ACK_WR,
    ST_RD,
    ST_MACK,
    ST_SKIP
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  // idle bus level is high, so reset to 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '1;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
  assign start_o    = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_q & ~sda_q & sda_s_i;
endmodule

// File: rtl/i2c_word_target.sv
module i2c_word_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'b1101000,
  parameter int         AW         = 6,
  parameter int         DW         = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pwr_fail_i,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_drive_low_o,
  output logic [AW-1:0] reg_addr_o,
  output logic          reg_we_o,
  output logic [DW-1:0] reg_wdata_o,
  input  logic [DW-1:0] reg_rdata_i
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] BITS_FULL = CW'(DW);
  localparam logic [CW-1:0] BIT_LAST  = CW'(DW - 1);

  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_c, stop_c;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(scl_i), .q_o(scl_s));
  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sda_i), .q_o(sda_s));

  i2c_tgt_cond u_cond (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .scl_s_i(scl_s), .sda_s_i(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_c), .stop_o(stop_c));

  tgt_state_e    state_q;
  logic [AW-1:0] ptr_q;
  logic [DW-1:0] shift_q, tx_q, wdata_q;
  logic [CW-1:0] cnt_q;
  logic          drv_q, rw_q, we_q, mack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      shift_q <= '0;
      tx_q    <= '0;
      wdata_q <= '0;
      cnt_q   <= '0;
      drv_q   <= 1'b0;
      rw_q    <= 1'b0;
      we_q    <= 1'b0;
      mack_q  <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (pwr_fail_i) begin
        state_q <= ST_IDLE;
        ptr_q   <= '0;
        drv_q   <= 1'b0;
        cnt_q   <= '0;
      end else if (start_c) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        drv_q   <= 1'b0;
      end else if (stop_c) begin
        state_q <= ST_IDLE;
        drv_q   <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_PTR, ST_WR: begin
            if (scl_rise) begin
              shift_q <= {shift_q[DW-2:0], sda_s};
              cnt_q   <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == BITS_FULL) begin
              cnt_q <= '0;
              if (state_q == ST_ADDR) begin
                if (shift_q[DW-1:1] == DEV_ADDR) begin
                  rw_q    <= shift_q[0];
                  drv_q   <= 1'b1;
                  state_q <= ST_ACK_ADDR;
                end else begin
                  state_q <= ST_SKIP;
                end
              end else if (state_q == ST_PTR) begin
                ptr_q   <= shift_q[AW-1:0];
                drv_q   <= 1'b1;
                state_q <= ST_ACK_PTR;
              end else begin
                we_q    <= 1'b1;
                wdata_q <= shift_q;
                drv_q   <= 1'b1;
                state_q <= ST_ACK_WR;
              end
            end
          end
          ST_ACK_ADDR: if (scl_fall) begin
            if (rw_q) begin
              tx_q    <= reg_rdata_i;
              drv_q   <= ~reg_rdata_i[DW-1];
              state_q <= ST_RD;
            end else begin
              drv_q   <= 1'b0;
              state_q <= ST_PTR;
            end
          end
          ST_ACK_PTR: if (scl_fall) begin
            drv_q   <= 1'b0;
            state_q <= ST_WR;
          end
          ST_ACK_WR: if (scl_fall) begin
            drv_q   <= 1'b0;
            ptr_q   <= ptr_q + 1'b1;
            state_q <= ST_WR;
          end
          ST_RD: if (scl_fall) begin
            if (cnt_q == BIT_LAST) begin
              cnt_q   <= '0;
              drv_q   <= 1'b0;
              state_q <= ST_MACK;
            end else begin
              cnt_q <= cnt_q + 1'b1;
              tx_q  <= {tx_q[DW-2:0], 1'b0};
              drv_q <= ~tx_q[DW-2];
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_s;
              if (!sda_s) ptr_q <= ptr_q + 1'b1;
            end else if (scl_fall) begin
              if (mack_q) begin
                tx_q    <= reg_rdata_i;
                drv_q   <= ~reg_rdata_i[DW-1];
                state_q <= ST_RD;
              end else begin
                state_q <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_drive_low_o = drv_q;
  assign reg_addr_o      = ptr_q;
  assign reg_we_o        = we_q;
  assign reg_wdata_o     = wdata_q;

  // R8: power fail releases the line and clears the pointer
  a_r8_release_on_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_fail_i |=> !sda_drive_low_o);
  a_r8_ptr_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_fail_i |=> reg_addr_o == '0);
  // R9: one strobe per byte, address steady across it
  a_r9_we_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);
  a_r9_addr_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o && !pwr_fail_i) |=> $stable(reg_addr_o));
  // R2: pull-down only begins while SCL is low
  a_r2_drive_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_drive_low_o) |-> !scl_s);
endmodule

// File: tb/i2c_word_target_bench.sv
module i2c_word_target_bench;
  localparam int H = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, pwr_fail, m_scl, m_sda;
  logic       drv, we;
  logic [5:0] raddr;
  logic [7:0] wdata, rdata;
  logic       ovr_en, ovr_arm;
  logic [7:0] ovr_val;
  logic [7:0] mem [64];
  logic [7:0] exp_mem [64];
  logic [5:0] exp_ptr;
  int         we_count;
  int         checks = 0, failures = 0;
  bit         done = 1'b0;

  wire sda_line = m_sda & ~drv;
  assign rdata = ovr_en ? ovr_val : mem[raddr];

  i2c_word_target u_i2c_word_target (
    .clk_i(clk), .rst_ni(rst_n), .pwr_fail_i(pwr_fail),
    .scl_i(m_scl), .sda_i(sda_line), .sda_drive_low_o(drv),
    .reg_addr_o(raddr), .reg_we_o(we), .reg_wdata_o(wdata), .reg_rdata_i(rdata));

  function automatic logic [7:0] init_val(int i);
    return 8'(i * 7 + 3);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= init_val(i);
      we_count <= 0;
    end else if (we) begin
      mem[raddr] <= wdata;
      we_count   <= we_count + 1;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(H);
    m_scl = 1'b1; tick(H);
    m_sda = 1'b0; tick(H);
    m_scl = 1'b0; tick(1);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(H);
    m_scl = 1'b1; tick(H);
    m_sda = 1'b1; tick(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(H);
      m_scl = 1'b1; tick(H);
      m_scl = 1'b0; tick(1);
    end
    m_sda = 1'b1; tick(H);
    m_scl = 1'b1; tick(H / 2);
    ack = ~sda_line;
    tick(H / 2);
    m_scl = 1'b0; tick(1);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    b = '0;
    m_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (ovr_arm && i == 2) begin
        ovr_val = ~mem[raddr];
        ovr_en  = 1'b1;
      end
      tick(H);
      m_scl = 1'b1; tick(H / 2);
      b = {b[6:0], sda_line};
      tick(H / 2);
      m_scl = 1'b0; tick(1);
    end
    ovr_en = 1'b0;
    ovr_arm = 1'b0;
    m_sda = ~give_ack; tick(H);
    m_scl = 1'b1; tick(H);
    m_scl = 1'b0; tick(1);
    m_sda = 1'b1;
  endtask

  task automatic wr_txn(input logic [7:0] pb, input int n, input string req);
    bit a;
    logic [7:0] d;
    bus_start();
    send_byte(8'hD0, a); check(a, "R1", "write address ack", a, 1);
    send_byte(pb, a);    check(a, req, "pointer ack", a, 1);
    exp_ptr = pb[5:0];
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      send_byte(d, a); check(a, "R3", "data ack", a, 1);
      exp_mem[exp_ptr] = d;
      exp_ptr = exp_ptr + 1'b1;
    end
    bus_stop();
    tick(2);
    begin
      bit same = 1'b1;
      for (int i = 0; i < 64; i++) if (mem[i] !== exp_mem[i]) same = 1'b0;
      check(same, req, "stored bytes match", same, 1);
    end
    check(raddr == exp_ptr, req, "pointer after write", raddr, exp_ptr);
  endtask

  task automatic rd_txn(input bit set_ptr, input logic [7:0] pb, input int n, input string req);
    bit a;
    logic [7:0] b;
    logic [7:0] e;
    bus_start();
    if (set_ptr) begin
      send_byte(8'hD0, a); check(a, "R1", "write address ack", a, 1);
      send_byte(pb, a);    check(a, "R4", "pointer ack", a, 1);
      exp_ptr = pb[5:0];
      bus_start();  // R2 repeated START
    end
    send_byte(8'hD1, a); check(a, "R2", "read address ack", a, 1);
    for (int k = 0; k < n; k++) begin
      e = exp_mem[exp_ptr];
      recv_byte(k != n - 1, b);
      check(b == e, req, "read byte", b, e);
      if (k != n - 1) exp_ptr = exp_ptr + 1'b1;
    end
    check(drv == 1'b0, "R5", "released after NACK", drv, 0);
    bus_stop();
    tick(2);
    check(raddr == exp_ptr, req, "pointer after read", raddr, exp_ptr);
  endtask

  initial begin
    bit a;
    int c;
    void'($urandom(32'd1234));
    rst_n = 1'b0; pwr_fail = 1'b0; m_scl = 1'b1; m_sda = 1'b1;
    ovr_en = 1'b0; ovr_arm = 1'b0; ovr_val = '0;
    for (int i = 0; i < 64; i++) exp_mem[i] = init_val(i);
    exp_ptr = '0;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    // R9 reset state
    check(drv == 1'b0, "R9", "reset drive", drv, 0);
    check(raddr == 6'd0, "R9", "reset pointer", raddr, 0);
    check(we == 1'b0, "R9", "reset strobe", we, 0);

    // R6 current read straight after reset
    rd_txn(1'b0, 8'h00, 2, "R6");
    // R3 pointer from low 6 bits
    wr_txn(8'hC5, 3, "R3");
    rd_txn(1'b1, 8'h05, 3, "R4");
    // R6 current read after a write
    wr_txn(8'd20, 2, "R6");
    rd_txn(1'b0, 8'h00, 1, "R6");
    // R5 NACK keeps the pointer
    rd_txn(1'b1, 8'd10, 3, "R5");
    rd_txn(1'b0, 8'h00, 1, "R5");
    // R7 wrap on write and read
    wr_txn(8'd62, 4, "R7");
    rd_txn(1'b1, 8'd62, 4, "R7");

    // R1 foreign address ignored
    c = we_count;
    bus_start();
    send_byte(8'hD2, a); check(!a, "R1", "foreign address nack", a, 0);
    send_byte(8'h05, a);
    send_byte(8'hAA, a);
    bus_stop(); tick(2);
    check(we_count == c, "R1", "no write for foreign address", we_count, c);
    check(raddr == exp_ptr, "R1", "pointer untouched", raddr, exp_ptr);

    // R10 read data latched at acknowledge
    ovr_arm = 1'b1;
    rd_txn(1'b1, 8'd40, 2, "R10");

    // R8 power fail mid-write
    bus_start();
    send_byte(8'hD0, a); check(a, "R1", "address ack", a, 1);
    send_byte(8'd30, a); check(a, "R3", "pointer ack", a, 1);
    pwr_fail = 1'b1; tick(3);
    check(raddr == 6'd0, "R8", "pointer cleared", raddr, 0);
    check(drv == 1'b0, "R8", "line released", drv, 0);
    c = we_count;
    send_byte(8'h5A, a); check(!a, "R8", "data ignored", a, 0);
    bus_stop();
    bus_start();
    send_byte(8'hD1, a); check(!a, "R8", "address ignored", a, 0);
    bus_stop(); tick(2);
    check(we_count == c, "R8", "no write during fail", we_count, c);
    pwr_fail = 1'b0; tick(4);
    exp_ptr = '0;
    rd_txn(1'b0, 8'h00, 1, "R8");

    // constrained random mix
    for (int it = 0; it < 40; it++) begin
      int op = int'($urandom % 3);
      logic [7:0] pb = 8'($urandom);
      int n = 1 + int'($urandom % 5);
      if (op == 0)      wr_txn(pb, n, "R3");
      else if (op == 1) rd_txn(1'b1, pb, n, "R4");
      else              rd_txn(1'b0, 8'h00, n, "R6");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule